// File: doc/BRIEF.md
# I2C Byte Buffer Controller

This block sits between a CPU and the bit-level engine of an I2C port that can work either as a master or as a slave. It holds one transmit byte written by the CPU and decides when that byte moves into the output (shift) stage. The decision depends on the role, on whether the incoming calling address matched, on the direction bit and on the acknowledge bit that was sampled after each byte. When the far side does not acknowledge, the block does not transfer the byte. As a slave it asks the engine to release SDA. As a master it asks the engine to end the transfer.

On the receive side the block presents a read-only byte register to the CPU, together with a full flag and an interrupt flag. Behind that register sits one pending slot, so a byte that arrives while the register is still unread is not lost. In slave mode a matched calling address is delivered through the same register as data. In master mode only data bytes reach it. All bus activity is modelled by single-cycle event inputs from the engine.

Top module: `i2c_bufctl`

## Requirements
- R1: While `en` is 0, every event input and every CPU access is ignored: no flag, register or output pulse changes.
- R2: In slave mode (`is_master`=0), an address event with `addr_match`=1 and `dir_rw`=1 (read requested) pulses `shift_load` one cycle later and copies the holding byte to `shift_data`. An unmatched address or a write-direction address loads nothing, and `shift_data` changes only on a load.
- R3: In slave mode, while this slave is transmitting, an acknowledge event with `ack_bit`=0 (ACK) loads the holding byte into the output stage.
- R4: In slave mode, an acknowledge event with `ack_bit`=1 (NACK) during a slave transmit pulses `sda_release`, loads nothing and leaves `tx_empty` at 0. Later ACK events load nothing, and the held byte is next loaded at the next matched read addressing.
- R5: In master mode, an ACK that follows an address event sent with `dir_rw`=0 (write) loads the holding byte. After a read-direction address, an ACK loads nothing.
- R6: In master mode, an ACK after a transmitted data byte loads the next holding byte. A NACK pulses `stop_req`, loads nothing and leaves `tx_empty` at 0.
- R7: `tx_empty` goes to 1 when a byte is loaded into the output stage and to 0 on a CPU write. When a write and a load fall in the same cycle, the old byte is loaded and `tx_empty` ends at 0.
- R8: In slave mode, a matched address event places the address byte (`bus_byte`) into `rx_data` like a received byte. An unmatched address leaves the receive side untouched.
- R9: In master mode, address events never touch the receive side. A received data byte event loads `bus_byte` into `rx_data`.
- R10: Each load of `rx_data` sets `rx_full` and `rx_irq`. A byte arriving while `rx_full`=1 waits in the pending slot. A CPU read clears `rx_full` and, if a byte is pending, loads it at once, setting `rx_full` and `rx_irq` again.
- R11: A `cpu_rxif_clr` pulse clears `rx_irq`. A load in the same cycle wins, leaving `rx_irq` at 1.
- R12: After reset `tx_empty`=1, `rx_full`=0, `rx_irq`=0, and `rx_data` and `shift_data` are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| cpu_tx_wr | input | 1 | CPU write strobe for the transmit holding byte |
| cpu_tx_data | input | 8 | Byte written by the CPU |
| cpu_rx_rd | input | 1 | CPU read strobe for the receive register |
| cpu_rxif_clr | input | 1 | CPU write-one-to-clear of the receive interrupt flag |
| ev_addr | input | 1 | Engine event: address phase finished |
| addr_match | input | 1 | Slave address matched (valid with ev_addr) |
| dir_rw | input | 1 | Direction bit of the address, 1 = read |
| ev_ack | input | 1 | Engine event: acknowledge bit sampled after a sent byte |
| ack_bit | input | 1 | Sampled acknowledge, 0 = ACK, 1 = NACK |
| ev_rx_byte | input | 1 | Engine event: data byte received |
| bus_byte | input | 8 | Address byte on ev_addr, data byte on ev_rx_byte |
| shift_load | output | 1 | One-cycle pulse: output stage loaded |
| shift_data | output | 8 | Output stage byte for the engine |
| sda_release | output | 1 | One-cycle pulse: slave releases SDA after NACK |
| stop_req | output | 1 | One-cycle pulse: master asks for STOP or repeated START |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_data | output | 8 | Receive register |
| rx_full | output | 1 | Receive register holds an unread byte |
| rx_irq | output | 1 | Receive interrupt flag |

## Verification
The assertions assume that the engine never raises `ev_addr`, `ev_ack` and `ev_rx_byte` in the same cycle. They also assume an acknowledge event comes only after a byte or address was sent, and that the role does not change in the middle of a transfer. The directed tasks drive at most one event per cycle and change `is_master` only between transfers. They combine CPU strobes with events only where a requirement defines the collision, such as a write during a load or a flag clear during a receive load.

// File: rtl/i2cbuf_pkg.sv
package i2cbuf_pkg;

    // What the transfer decoder asks the transmit path to do this cycle
    typedef enum logic [1:0] {
        XF_NONE = 2'd0,
        XF_LOAD = 2'd1,
        XF_REL  = 2'd2,
        XF_STOP = 2'd3
    } xfer_act_e;

endpackage

// File: rtl/i2cbuf_xfer_dec.sv
module i2cbuf_xfer_dec
    import i2cbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      is_master,
    input  logic      ev_addr,
    input  logic      addr_match,
    input  logic      dir_rw,
    input  logic      ev_ack,
    input  logic      ack_bit,
    output xfer_act_e act
);

    typedef struct packed {
        logic slv_tx;   // this slave is sending to a reading master
        logic mst_tx;   // this master addressed a slave for writing
    } dec_st_t;

    dec_st_t st_q, st_d;
    xfer_act_e act_d;

    always_comb begin
        st_d  = st_q;
        act_d = XF_NONE;
        if (en) begin
            if (!is_master) begin
                st_d.mst_tx = 1'b0;
                if (ev_addr) begin
                    st_d.slv_tx = addr_match && dir_rw;
                    if (addr_match && dir_rw) begin
                        act_d = XF_LOAD;
                    end
                end else if (ev_ack && st_q.slv_tx) begin
                    if (!ack_bit) begin
                        act_d = XF_LOAD;
                    end else begin
                        act_d       = XF_REL;
                        st_d.slv_tx = 1'b0;
                    end
                end
            end else begin
                st_d.slv_tx = 1'b0;
                if (ev_addr) begin
                    st_d.mst_tx = !dir_rw;
                end else if (ev_ack && st_q.mst_tx) begin
                    if (!ack_bit) begin
                        act_d = XF_LOAD;
                    end else begin
                        act_d       = XF_STOP;
                        st_d.mst_tx = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act = act_d;

    AST_ROLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.slv_tx && st_q.mst_tx)); // R2

endmodule

// File: rtl/i2cbuf_tx_path.sv
module i2cbuf_tx_path
    import i2cbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  xfer_act_e         act,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_data,
    output logic              load_p,
    output logic [DATA_W-1:0] shift_byte,
    output logic              rel_p,
    output logic              stop_p,
    output logic              empty
);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] shift;
        logic              empty;
        logic              load_p;
        logic              rel_p;
        logic              stop_p;
    } tx_st_t;

    tx_st_t q, d;

    always_comb begin
        d        = q;
        d.load_p = 1'b0;
        d.rel_p  = 1'b0;
        d.stop_p = 1'b0;
        if (en) begin
            unique case (act)
                XF_LOAD: begin
                    d.shift  = q.hold;
                    d.load_p = 1'b1;
                    d.empty  = 1'b1;
                end
                XF_REL:  d.rel_p  = 1'b1;
                XF_STOP: d.stop_p = 1'b1;
                default: ;
            endcase
            // a CPU write lands after the move, so it refills the holding byte
            if (cpu_wr) begin
                d.hold  = cpu_data;
                d.empty = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.empty <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign load_p     = q.load_p;
    assign shift_byte = q.shift;
    assign rel_p      = q.rel_p;
    assign stop_p     = q.stop_p;
    assign empty      = q.empty;

    AST_SHIFT_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !q.load_p |-> $stable(q.shift)); // R2
    AST_EMPTY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        q.load_p |-> (q.empty || $past(cpu_wr && en))); // R7

endmodule

// File: rtl/i2cbuf_rx_path.sv
module i2cbuf_rx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              rd,
    input  logic              irq_clr,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              irq
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] pend;
        logic              pend_v;
        logic              full;
        logic              irq;
    } rx_st_t;

    rx_st_t q, d;
    logic   fill;

    always_comb begin
        d    = q;
        fill = 1'b0;
        if (en) begin
            if (rd) begin
                d.full = 1'b0;
                if (q.pend_v) begin
                    d.data   = q.pend;
                    d.full   = 1'b1;
                    d.pend_v = 1'b0;
                    fill     = 1'b1;
                end
            end
            if (in_valid) begin
                if (!q.full || (rd && !q.pend_v)) begin
                    d.data = in_byte;
                    d.full = 1'b1;
                    fill   = 1'b1;
                end else begin
                    // register still occupied: park the newest byte
                    d.pend   = in_byte;
                    d.pend_v = 1'b1;
                end
            end
            if (irq_clr) begin
                d.irq = 1'b0;
            end
            if (fill) begin
                d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data = q.data;
    assign full = q.full;
    assign irq  = q.irq;

    AST_PEND_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend_v |-> q.full); // R10
    AST_IRQ_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.full) |-> q.irq); // R10

endmodule

// File: rtl/i2c_bufctl.sv
module i2c_bufctl
    import i2cbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              is_master,
    input  logic              cpu_tx_wr,
    input  logic [DATA_W-1:0] cpu_tx_data,
    input  logic              cpu_rx_rd,
    input  logic              cpu_rxif_clr,
    input  logic              ev_addr,
    input  logic              addr_match,
    input  logic              dir_rw,
    input  logic              ev_ack,
    input  logic              ack_bit,
    input  logic              ev_rx_byte,
    input  logic [DATA_W-1:0] bus_byte,
    output logic              shift_load,
    output logic [DATA_W-1:0] shift_data,
    output logic              sda_release,
    output logic              stop_req,
    output logic              tx_empty,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_irq
);

    xfer_act_e act;
    logic      rx_in_valid;

    // matched slave address goes through the receive register like data
    assign rx_in_valid = ev_rx_byte || (ev_addr && !is_master && addr_match);

    i2cbuf_xfer_dec u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .is_master  (is_master),
        .ev_addr    (ev_addr),
        .addr_match (addr_match),
        .dir_rw     (dir_rw),
        .ev_ack     (ev_ack),
        .ack_bit    (ack_bit),
        .act        (act)
    );

    i2cbuf_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .act        (act),
        .cpu_wr     (cpu_tx_wr),
        .cpu_data   (cpu_tx_data),
        .load_p     (shift_load),
        .shift_byte (shift_data),
        .rel_p      (sda_release),
        .stop_p     (stop_req),
        .empty      (tx_empty)
    );

    i2cbuf_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .in_valid (rx_in_valid),
        .in_byte  (bus_byte),
        .rd       (cpu_rx_rd),
        .irq_clr  (cpu_rxif_clr),
        .data     (rx_data),
        .full     (rx_full),
        .irq      (rx_irq)
    );

    AST_LOAD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        shift_load |-> $past(en)); // R1
    AST_RELEASE_ON_SLAVE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        sda_release |-> $past(!is_master && ev_ack && ack_bit)); // R4
    AST_STOP_ON_MASTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> $past(is_master && ev_ack && ack_bit)); // R6
    AST_NACK_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_release || stop_req) |-> !shift_load); // R6

endmodule

// File: tb/tb_i2c_bufctl.sv
`timescale 1ns/1ps
module tb_i2c_bufctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       is_master = 1'b0;
    logic       cpu_tx_wr = 1'b0;
    logic [7:0] cpu_tx_data = '0;
    logic       cpu_rx_rd = 1'b0;
    logic       cpu_rxif_clr = 1'b0;
    logic       ev_addr = 1'b0;
    logic       addr_match = 1'b0;
    logic       dir_rw = 1'b0;
    logic       ev_ack = 1'b0;
    logic       ack_bit = 1'b0;
    logic       ev_rx_byte = 1'b0;
    logic [7:0] bus_byte = '0;
    logic       shift_load, sda_release, stop_req, tx_empty, rx_full, rx_irq;
    logic [7:0] shift_data, rx_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    i2c_bufctl dut (
        .clk(clk), .rst_n(rst_n), .en(en), .is_master(is_master),
        .cpu_tx_wr(cpu_tx_wr), .cpu_tx_data(cpu_tx_data),
        .cpu_rx_rd(cpu_rx_rd), .cpu_rxif_clr(cpu_rxif_clr),
        .ev_addr(ev_addr), .addr_match(addr_match), .dir_rw(dir_rw),
        .ev_ack(ev_ack), .ack_bit(ack_bit), .ev_rx_byte(ev_rx_byte),
        .bus_byte(bus_byte), .shift_load(shift_load), .shift_data(shift_data),
        .sda_release(sda_release), .stop_req(stop_req), .tx_empty(tx_empty),
        .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock edge, then release every strobe; we end at a negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cpu_tx_wr = 0; cpu_rx_rd = 0; cpu_rxif_clr = 0;
        ev_addr = 0; ev_ack = 0; ev_rx_byte = 0;
    endtask

    task automatic wr(input logic [7:0] b);
        cpu_tx_wr = 1; cpu_tx_data = b; step();
    endtask
    task automatic addr(input logic m, input logic rw, input logic [7:0] b);
        ev_addr = 1; addr_match = m; dir_rw = rw; bus_byte = b; step();
    endtask
    task automatic ack(input logic nack);
        ev_ack = 1; ack_bit = nack; step();
    endtask
    task automatic rxb(input logic [7:0] b);
        ev_rx_byte = 1; bus_byte = b; step();
    endtask
    task automatic rd_clr();
        cpu_rx_rd = 1; cpu_rxif_clr = 1; step();
    endtask

    task automatic t_reset();
        chk("R12 tx_empty", tx_empty, 1);
        chk("R12 rx_full", rx_full, 0);
        chk("R12 rx_irq", rx_irq, 0);
        chk("R12 rx_data", rx_data, 8'h00);
        chk("R12 shift_data", shift_data, 8'h00);
    endtask

    task automatic t_slave_tx();
        wr(8'hA5);
        chk("R7 write clears empty", tx_empty, 0);
        addr(1, 1, 8'h42);
        chk("R2 load pulse", shift_load, 1);
        chk("R2 shift byte", shift_data, 8'hA5);
        chk("R7 empty after load", tx_empty, 1);
        chk("R8 address in rx", rx_data, 8'h42);
        chk("R8 rx_full", rx_full, 1);
        chk("R10 irq", rx_irq, 1);
        rd_clr();
        wr(8'h3C);
        ack(0);
        chk("R3 load on ack", shift_load, 1);
        chk("R3 shift byte", shift_data, 8'h3C);
        wr(8'h77);
        ack(1);
        chk("R4 release", sda_release, 1);
        chk("R4 no load", shift_load, 0);
        chk("R4 empty stays 0", tx_empty, 0);
        chk("R4 shift kept", shift_data, 8'h3C);
        ack(0);
        chk("R4 no load after release", shift_load, 0);
        addr(1, 1, 8'h42);
        chk("R4 held byte on readdress", shift_load, 1);
        chk("R4 held byte value", shift_data, 8'h77);
        rd_clr();
    endtask

    task automatic t_slave_other();
        wr(8'h99);
        addr(0, 1, 8'h13);
        chk("R2 unmatched no load", shift_load, 0);
        chk("R8 unmatched no rx", rx_full, 0);
        addr(1, 0, 8'h42);
        chk("R2 write dir no load", shift_load, 0);
        chk("R8 write dir addr rx", rx_data, 8'h42);
        rd_clr();
    endtask

    task automatic t_same_cycle();
        cpu_tx_wr = 1; cpu_tx_data = 8'hC1;
        addr(1, 1, 8'h42);
        chk("R7 old byte loaded", shift_data, 8'h99);
        chk("R7 empty stays 0", tx_empty, 0);
        ack(0);
        chk("R7 new byte next", shift_data, 8'hC1);
        chk("R7 empty after", tx_empty, 1);
        rd_clr();
    endtask

    task automatic t_master();
        is_master = 1;
        wr(8'h11);
        addr(1, 0, 8'h90);
        chk("R5 no load on address", shift_load, 0);
        chk("R9 address not in rx", rx_full, 0);
        ack(0);
        chk("R5 load after address ack", shift_load, 1);
        chk("R5 byte", shift_data, 8'h11);
        wr(8'h22);
        ack(0);
        chk("R6 data ack load", shift_data, 8'h22);
        wr(8'h33);
        ack(1);
        chk("R6 stop", stop_req, 1);
        chk("R6 no load", shift_load, 0);
        chk("R6 empty stays 0", tx_empty, 0);
        chk("R6 shift kept", shift_data, 8'h22);
        addr(1, 1, 8'h91);
        ack(0);
        chk("R5 read dir no load", shift_load, 0);
        rxb(8'h5A);
        chk("R9 data byte", rx_data, 8'h5A);
        chk("R9 full", rx_full, 1);
        rd_clr();
    endtask

    task automatic t_rx_queue();
        rxb(8'h01);
        chk("R10 first", rx_data, 8'h01);
        cpu_rxif_clr = 1; step();
        chk("R11 clear", rx_irq, 0);
        rxb(8'h02);
        chk("R10 held while full", rx_data, 8'h01);
        chk("R10 no irq while pending", rx_irq, 0);
        cpu_rx_rd = 1; step();
        chk("R10 pending loaded", rx_data, 8'h02);
        chk("R10 full again", rx_full, 1);
        chk("R10 irq again", rx_irq, 1);
        cpu_rx_rd = 1; step();
        chk("R10 read empties", rx_full, 0);
    endtask

    task automatic t_irq();
        cpu_rxif_clr = 1; step();
        chk("R11 cleared", rx_irq, 0);
        ev_rx_byte = 1; bus_byte = 8'h04; cpu_rxif_clr = 1; step();
        chk("R11 load wins", rx_irq, 1);
        chk("R11 data", rx_data, 8'h04);
        cpu_rx_rd = 1; step();
    endtask

    task automatic t_disable();
        en = 0;
        cpu_tx_wr = 1; cpu_tx_data = 8'hEE; ev_rx_byte = 1; bus_byte = 8'h55;
        cpu_rxif_clr = 1; step();
        chk("R1 tx_empty", tx_empty, 0);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 rx_data", rx_data, 8'h04);
        chk("R1 rx_irq", rx_irq, 1);
        addr(1, 0, 8'h90);
        ack(0);
        chk("R1 no load", shift_load, 0);
        en = 1;
        addr(1, 0, 8'h90);
        ack(0);
        chk("R1 write was ignored", shift_data, 8'h33);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_slave_tx();
        t_slave_other();
        t_same_cycle();
        t_master();
        t_rx_queue();
        t_irq();
        t_disable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule